// File: doc/BRIEF.md
# Receive FIFO and Interrupt Prioritizer for a 16550-Style Serial Port

This block sits between a serial receiver and the host CPU. Each character the receiver delivers arrives on a write port with three error flags: framing, parity and break. The block stores the character and its flags together in a first-in first-out buffer. The CPU reads the oldest character from a head port, along with that character's own flags and the current fill level. A separate output is high while any stored character carries an error.

The block keeps the interrupt-enable register and the FIFO control register. The FIFO control register turns FIFO mode on or off, picks one of four receive trigger levels and clears the buffer. While characters wait below the trigger level, a character time-out counter watches for receive activity. The block merges five request sources into one 4-bit interrupt identification code, which the CPU can read at any time. The sources are line status, receive data, time-out, transmitter empty and modem status. A reset of the design leaves the interrupt-enable register at zero and FIFO mode off.

The block drives a single interrupt line. A read of the status register acknowledges a pending transmitter-empty interrupt. The parameter DEPTH must be a power of two. CHAR_CLKS is the number of clock cycles in one character time.

Top module: `uart_rx_irq_hub`

## Requirements
- R1: The buffer holds up to DEPTH (default 64) entries of 8 data bits plus framing, parity and break flags. The head port always shows the oldest stored entry with its own flags, and each accepted read removes that entry.
- R2: A write while the buffer is full is discarded and the level stays at DEPTH. A read while the buffer is empty has no effect. The level never exceeds DEPTH.
- R3: FCR bits 7:6 select the trigger level: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 56 entries. FCR bit 0 enables FIFO mode; with it clear, the trigger level is 1. With IER bit 0 set and the level at or above the trigger level, the code is 0100.
- R4: In FIFO mode, with IER bit 0 set, a non-empty buffer raises the time-out code 1100 once no write or read has been accepted for 4×CHAR_CLKS cycles. Any accepted write or read restarts that count.
- R5: With IER bit 2 set, the code is 0110 while the head entry carries any error flag.
- R6: The error indication is high exactly while at least one entry in the buffer carries an error flag.
- R7: A rising edge of the transmitter-empty input sets a pending flag. The flag clears when that input goes low, or when an ISR read occurs while the code is 0010. With IER bit 1 set, the pending flag gives the code 0010.
- R8: With IER bit 3 set, the code is 0000 while the modem-change input is high.
- R9: The priority, highest first, is line status (0110), then receive data (0100), then time-out (1100), then transmitter empty (0010), then modem (0000). The code 0001 means no request is active. The interrupt output is high exactly when the code is not 0001.
- R10: A write to the FCR with bit 1 set empties the buffer, clears the error count and restarts the time-out count. A write or read in that same cycle is discarded.
- R11: After reset, the level is 0, the error indication is low, the code is 0001 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_wr_valid | input | 1 | Write a received character this cycle |
| rx_wr_data | input | 8 | Received character |
| rx_wr_frame_err | input | 1 | Framing error flag of the written character |
| rx_wr_parity_err | input | 1 | Parity error flag of the written character |
| rx_wr_break | input | 1 | Break flag of the written character |
| rx_rd | input | 1 | CPU read: remove the head entry |
| rx_rd_data | output | 8 | Head entry character |
| rx_rd_frame_err | output | 1 | Head entry framing flag |
| rx_rd_parity_err | output | 1 | Head entry parity flag |
| rx_rd_break | output | 1 | Head entry break flag |
| rx_level | output | $clog2(DEPTH+1) | Number of stored entries |
| rx_err_any | output | 1 | At least one stored entry carries an error |
| ier_wr | input | 1 | Write the interrupt-enable register |
| ier_wdata | input | 4 | Enables: bit0 receive, bit1 transmit empty, bit2 line status, bit3 modem |
| fcr_wr | input | 1 | Write the FIFO control register |
| fcr_wdata | input | 8 | bit0 FIFO mode, bit1 clear buffer, bits 7:6 trigger select |
| isr_rd | input | 1 | CPU read of the interrupt status code |
| tx_empty | input | 1 | Transmitter holding register is empty |
| msr_delta | input | 1 | A modem input has changed |
| isr_code | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each strobe is a single-cycle, synchronous pulse. They also assume that the FCR clear bit is the only path that discards stored data, and that CHAR_CLKS is at least 1, so an accepted write can never be followed at once by a time-out. The stimulus changes inputs only just after a rising edge and returns every strobe to zero after one cycle. It issues reads and writes to a full or empty buffer only as deliberate corner cases. The modem-change and transmitter-empty inputs are held as levels for several cycles.

// File: rtl/uart_rxirq_pkg.sv
package uart_rxirq_pkg;

  typedef struct packed {
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [3:0] {
    IRQ_MODEM   = 4'b0000,
    IRQ_NONE    = 4'b0001,
    IRQ_TXEMPTY = 4'b0010,
    IRQ_RXDATA  = 4'b0100,
    IRQ_LINE    = 4'b0110,
    IRQ_TIMEOUT = 4'b1100
  } irq_code_e;

  localparam int unsigned N_SRC = 5;

  // Trigger threshold for a select value, clamped to the buffer depth.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    int unsigned t;
    case (sel)
      2'b00:   t = 1;
      2'b01:   t = 16;
      2'b10:   t = 32;
      default: t = 56;
    endcase
    return (t > depth) ? depth : t;
  endfunction

  function automatic logic entry_bad(input rx_entry_t e);
    return e.brk | e.par | e.frm;
  endfunction

  // Priority slot -> identification code; slot 0 is the highest priority.
  function automatic irq_code_e slot_code(input int unsigned slot);
    case (slot)
      0:       return IRQ_LINE;
      1:       return IRQ_RXDATA;
      2:       return IRQ_TIMEOUT;
      3:       return IRQ_TXEMPTY;
      default: return IRQ_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import uart_rxirq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  output rx_entry_t     head,
  output logic [CW-1:0] level,
  output logic          err_any,
  output logic          push_ok,
  output logic          pop_ok
);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] err_cnt;
  logic          full;
  logic          empty;
  logic          push_bad;
  logic          pop_bad;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign push_ok  = push && !full && !clr;
  assign pop_ok   = pop && !empty && !clr;
  assign head     = mem[rd_ptr];
  assign push_bad = push_ok && entry_bad(push_entry);
  assign pop_bad  = pop_ok && entry_bad(head);
  assign level    = cnt;
  assign err_any  = (err_cnt != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      cnt     <= cnt + CW'(push_ok) - CW'(pop_ok);
      err_cnt <= err_cnt + CW'(push_bad) - CW'(pop_bad);
    end
  end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic fire
);

  logic [TW-1:0] cnt;

  assign fire = (cnt == TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!fire)   cnt <= cnt + TW'(1);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import uart_rxirq_pkg::*;
(
  input  logic [N_SRC-1:0] req,
  output irq_code_e        code
);

  // Walk from lowest to highest priority so the highest active slot wins.
  always_comb begin
    code = IRQ_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) code = slot_code(i);
    end
  end

endmodule

// File: rtl/uart_rx_irq_hub.sv
module uart_rx_irq_hub
  import uart_rxirq_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned CHAR_CLKS = 160,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_wr_valid,
  input  logic [7:0]    rx_wr_data,
  input  logic          rx_wr_frame_err,
  input  logic          rx_wr_parity_err,
  input  logic          rx_wr_break,
  input  logic          rx_rd,
  output logic [7:0]    rx_rd_data,
  output logic          rx_rd_frame_err,
  output logic          rx_rd_parity_err,
  output logic          rx_rd_break,
  output logic [LW-1:0] rx_level,
  output logic          rx_err_any,
  input  logic          ier_wr,
  input  logic [3:0]    ier_wdata,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          isr_rd,
  input  logic          tx_empty,
  input  logic          msr_delta,
  output logic [3:0]    isr_code,
  output logic          irq
);

  localparam int unsigned TO_LIMIT = 4 * CHAR_CLKS;

  // Register state
  logic [3:0] ier_q;
  logic       fifo_en_q;
  logic [1:0] trig_sel_q;
  logic       tx_empty_q;
  logic       thre_pend;

  // Named internal events
  logic            fifo_clr;
  logic            push_ok;
  logic            pop_ok;
  logic            to_fire;
  logic            to_restart;
  logic [LW-1:0]   trig_cnt;
  logic            line_req;
  logic            rxd_req;
  logic            to_req;
  logic            tx_req;
  logic            ms_req;
  logic [N_SRC-1:0] req_vec;
  rx_entry_t       wr_entry;
  rx_entry_t       head;
  irq_code_e       code;
  logic            fcr_spare_unused;

  assign fcr_spare_unused = ^fcr_wdata[5:2];
  assign fifo_clr = fcr_wr && fcr_wdata[1];

  assign wr_entry = '{brk: rx_wr_break, par: rx_wr_parity_err,
                      frm: rx_wr_frame_err, data: rx_wr_data};

  rx_err_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_clr),
    .push       (rx_wr_valid),
    .push_entry (wr_entry),
    .pop        (rx_rd),
    .head       (head),
    .level      (rx_level),
    .err_any    (rx_err_any),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok)
  );

  assign to_restart = fifo_clr || push_ok || pop_ok || (rx_level == '0);

  rx_idle_timer #(.LIMIT(TO_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (to_restart),
    .fire    (to_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q      <= '0;
      fifo_en_q  <= 1'b0;
      trig_sel_q <= 2'b00;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      if (fcr_wr) begin
        fifo_en_q  <= fcr_wdata[0];
        trig_sel_q <= fcr_wdata[7:6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_q <= 1'b0;
      thre_pend  <= 1'b0;
    end else begin
      tx_empty_q <= tx_empty;
      if (!tx_empty)                       thre_pend <= 1'b0;
      else if (!tx_empty_q)                thre_pend <= 1'b1;
      else if (isr_rd && code == IRQ_TXEMPTY) thre_pend <= 1'b0;
    end
  end

  assign trig_cnt = fifo_en_q ? LW'(trig_level(trig_sel_q, DEPTH)) : LW'(1);

  assign line_req = ier_q[2] && (rx_level != '0) && entry_bad(head);
  assign rxd_req  = ier_q[0] && (rx_level >= trig_cnt);
  assign to_req   = ier_q[0] && fifo_en_q && (rx_level != '0) && to_fire;
  assign tx_req   = ier_q[1] && thre_pend;
  assign ms_req   = ier_q[3] && msr_delta;
  assign req_vec  = {ms_req, tx_req, to_req, rxd_req, line_req};

  irq_arbiter u_arb (
    .req  (req_vec),
    .code (code)
  );

  assign isr_code         = code;
  assign irq              = (code != IRQ_NONE);
  assign rx_rd_data       = head.data;
  assign rx_rd_frame_err  = head.frm;
  assign rx_rd_parity_err = head.par;
  assign rx_rd_break      = head.brk;

endmodule

// File: rtl/uart_rx_irq_hub_chk.sv
module uart_rx_irq_hub_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_wr_valid,
  input logic          rx_rd,
  input logic [LW-1:0] rx_level,
  input logic          rx_err_any,
  input logic          rx_rd_frame_err,
  input logic          rx_rd_parity_err,
  input logic          rx_rd_break,
  input logic          fcr_wr,
  input logic [7:0]    fcr_wdata,
  input logic [3:0]    ier,
  input logic [3:0]    isr_code
);

  logic head_bad;
  assign head_bad = rx_rd_frame_err | rx_rd_parity_err | rx_rd_break;

  // R2: level bounded by depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  // R2: a write to a full buffer leaves it full
  a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LW'(DEPTH) && rx_wr_valid && !rx_rd && !(fcr_wr && fcr_wdata[1]))
      |=> rx_level == LW'(DEPTH));

  // R10: clear empties buffer and error count
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_wdata[1]) |=> (rx_level == '0 && !rx_err_any));

  // R5: erroneous head with line enable wins
  a_r5_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != '0 && ier[2] && head_bad) |-> isr_code == 4'b0110);

  // R6: a flagged head implies the error indication
  a_r6_err_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != '0 && head_bad) |-> rx_err_any);

  // R4: time-out only with data present
  a_r4_timeout_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    isr_code == 4'b1100 |-> rx_level != '0);

  // R4: an accepted write restarts the time-out
  a_r4_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_valid && rx_level < LW'(DEPTH)) |=> isr_code != 4'b1100);

endmodule

bind uart_rx_irq_hub uart_rx_irq_hub_chk #(.DEPTH(DEPTH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rx_wr_valid      (rx_wr_valid),
  .rx_rd            (rx_rd),
  .rx_level         (rx_level),
  .rx_err_any       (rx_err_any),
  .rx_rd_frame_err  (rx_rd_frame_err),
  .rx_rd_parity_err (rx_rd_parity_err),
  .rx_rd_break      (rx_rd_break),
  .fcr_wr           (fcr_wr),
  .fcr_wdata        (fcr_wdata),
  .ier              (ier_q),
  .isr_code         (isr_code)
);

// File: tb/uart_rx_irq_hub_tb.sv
`timescale 1ns/1ps
module uart_rx_irq_hub_tb;

  localparam int DEPTH = 64;
  localparam int CHAR_CLKS = 4;
  localparam int LIMIT = 4 * CHAR_CLKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_wr_valid = 1'b0;
  logic [7:0] rx_wr_data = '0;
  logic       rx_wr_frame_err = 1'b0, rx_wr_parity_err = 1'b0, rx_wr_break = 1'b0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_rd_data;
  logic       rx_rd_frame_err, rx_rd_parity_err, rx_rd_break;
  logic [6:0] rx_level;
  logic       rx_err_any;
  logic       ier_wr = 1'b0;
  logic [3:0] ier_wdata = '0;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic       isr_rd = 1'b0;
  logic       tx_empty = 1'b0;
  logic       msr_delta = 1'b0;
  logic [3:0] isr_code;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_irq_hub #(.DEPTH(DEPTH), .CHAR_CLKS(CHAR_CLKS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_wr_valid(rx_wr_valid), .rx_wr_data(rx_wr_data),
    .rx_wr_frame_err(rx_wr_frame_err), .rx_wr_parity_err(rx_wr_parity_err),
    .rx_wr_break(rx_wr_break), .rx_rd(rx_rd),
    .rx_rd_data(rx_rd_data), .rx_rd_frame_err(rx_rd_frame_err),
    .rx_rd_parity_err(rx_rd_parity_err), .rx_rd_break(rx_rd_break),
    .rx_level(rx_level), .rx_err_any(rx_err_any),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .isr_rd(isr_rd), .tx_empty(tx_empty), .msr_delta(msr_delta),
    .isr_code(isr_code), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [10:0] q[$];          // {brk, par, frm, data}
  logic [3:0]  m_ier;
  bit          m_fen;
  logic [1:0]  m_trig;
  int          m_idle;
  bit          m_txq, m_thre;

  function automatic int trig_of();
    if (!m_fen) return 1;
    case (m_trig)
      2'b00: return 1;
      2'b01: return 16;
      2'b10: return 32;
      default: return 56;
    endcase
  endfunction

  function automatic logic [3:0] exp_code();
    if (m_ier[2] && q.size() > 0 && q[0][10:8] != 3'b000) return 4'b0110;
    if (m_ier[0] && q.size() >= trig_of()) return 4'b0100;
    if (m_ier[0] && m_fen && q.size() > 0 && m_idle >= LIMIT) return 4'b1100;
    if (m_ier[1] && m_thre) return 4'b0010;
    if (m_ier[3] && msr_delta) return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic bit exp_err();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ier = '0; m_fen = 0; m_trig = '0; m_idle = 0; m_txq = 0; m_thre = 0;
    end else begin
      automatic logic [3:0] c = exp_code();
      automatic bit clr = fcr_wr && fcr_wdata[1];
      automatic bit wr_ok = rx_wr_valid && q.size() < DEPTH && !clr;
      automatic bit rd_ok = rx_rd && q.size() > 0 && !clr;
      if (clr || wr_ok || rd_ok || q.size() == 0) m_idle = 0;
      else if (m_idle < LIMIT) m_idle++;
      if (clr) q.delete();
      else begin
        if (rd_ok) void'(q.pop_front());
        if (wr_ok) q.push_back({rx_wr_break, rx_wr_parity_err, rx_wr_frame_err, rx_wr_data});
      end
      if (!tx_empty) m_thre = 0;
      else if (!m_txq) m_thre = 1;
      else if (isr_rd && c == 4'b0010) m_thre = 0;
      m_txq = tx_empty;
      if (ier_wr) m_ier = ier_wdata;
      if (fcr_wr) begin m_fen = fcr_wdata[0]; m_trig = fcr_wdata[7:6]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R1 R6 R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic [3:0] ec = exp_code();
      chk(isr_code == ec, "R9 code vs model", isr_code, ec);
      chk(irq == (ec != 4'b0001), "R9 irq vs model", irq, ec != 4'b0001);
      chk(rx_level == q.size(), "R1 level vs model", rx_level, q.size());
      chk(rx_err_any == exp_err(), "R6 error indication vs model", rx_err_any, exp_err());
      if (q.size() > 0)
        chk({rx_rd_break, rx_rd_parity_err, rx_rd_frame_err, rx_rd_data} == q[0],
            "R1 head entry vs model",
            {rx_rd_break, rx_rd_parity_err, rx_rd_frame_err, rx_rd_data}, q[0]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
    rx_wr_valid = 0; rx_rd = 0; ier_wr = 0; fcr_wr = 0; isr_rd = 0;
    rx_wr_frame_err = 0; rx_wr_parity_err = 0; rx_wr_break = 0;
  endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic push(input logic [7:0] d, input logic [2:0] f);
    rx_wr_valid = 1; rx_wr_data = d;
    {rx_wr_break, rx_wr_parity_err, rx_wr_frame_err} = f; tick();
  endtask
  task automatic pop(); rx_rd = 1; tick(); endtask
  task automatic w_ier(input logic [3:0] v); ier_wr = 1; ier_wdata = v; tick(); endtask
  task automatic w_fcr(input logic [7:0] v); fcr_wr = 1; fcr_wdata = v; tick(); endtask
  task automatic expect_code(input logic [3:0] e, input string tag);
    @(negedge clk); chk(isr_code == e, tag, isr_code, e);
  endtask
  task automatic expect_level(input int e, input string tag);
    @(negedge clk); chk(rx_level == e, tag, rx_level, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1; #1;
    @(negedge clk);
    chk(rx_level == 0 && !rx_err_any, "R11 reset empty", rx_level, 0);
    chk(isr_code == 4'b0001 && !irq, "R11 reset code idle", isr_code, 1);

    // Non-FIFO mode: trigger 1, no time-out
    w_ier(4'b0001);
    w_fcr(8'h00);
    push(8'hA5, 3'b000);
    expect_code(4'b0100, "R3 trigger one in non-FIFO mode");
    idle(LIMIT + 4);
    expect_code(4'b0100, "R3 still data available");
    pop();
    expect_code(4'b0001, "R9 idle after read");
    pop();
    expect_level(0, "R2 read of empty buffer ignored");

    // Trigger 16 and time-out
    w_fcr(8'h41);
    for (int i = 0; i < 15; i++) push(8'(i), 3'b000);
    expect_code(4'b0001, "R3 below trigger sixteen");
    idle(LIMIT + 2);
    expect_code(4'b1100, "R4 time-out after four character times");
    push(8'h0F, 3'b000);
    expect_code(4'b0100, "R3 trigger sixteen reached");
    pop();
    expect_code(4'b0001, "R4 read restarts time-out");
    idle(LIMIT + 2);
    expect_code(4'b1100, "R4 time-out again");

    // Clear, with a write in the same cycle discarded
    fcr_wr = 1; fcr_wdata = 8'h43; rx_wr_valid = 1; rx_wr_data = 8'h77; tick();
    expect_level(0, "R10 clear empties buffer");
    expect_code(4'b0001, "R10 code idle after clear");

    // Trigger 32
    w_fcr(8'h81);
    for (int i = 0; i < 31; i++) push(8'(8'h40 + i), 3'b000);
    expect_code(4'b0001, "R3 below trigger thirty-two");
    push(8'h5F, 3'b000);
    expect_code(4'b0100, "R3 trigger thirty-two reached");

    // Trigger 56 and overflow
    w_fcr(8'hC1);
    for (int i = 0; i < 23; i++) push(8'(8'h60 + i), 3'b000);
    expect_code(4'b0001, "R3 below trigger fifty-six");
    push(8'h77, 3'b000);
    expect_code(4'b0100, "R3 trigger fifty-six reached");
    for (int i = 0; i < 11; i++) push(8'(8'h80 + i), 3'b000);
    expect_level(64, "R2 buffer full");
    push(8'hEE, 3'b000);
    push(8'hEF, 3'b000);
    expect_level(64, "R2 writes to full buffer discarded");
    for (int i = 0; i < 64; i++) pop();
    expect_level(0, "R1 drained in order");

    // Error flags and line status
    w_ier(4'b0101);
    push(8'h11, 3'b000);
    push(8'h22, 3'b010);
    @(negedge clk);
    chk(rx_err_any == 1, "R6 error indication set", rx_err_any, 1);
    chk(isr_code == 4'b0001, "R5 clean head gives no line status", isr_code, 1);
    pop();
    expect_code(4'b0110, "R5 flagged head gives line status");
    pop();
    @(negedge clk);
    chk(rx_err_any == 0, "R6 error indication clears", rx_err_any, 0);

    // Transmitter empty
    w_ier(4'b0010);
    tx_empty = 1; tick();
    expect_code(4'b0010, "R7 transmitter empty pending");
    isr_rd = 1; tick();
    expect_code(4'b0001, "R7 status read acknowledges");
    tx_empty = 0; tick();
    tx_empty = 1; tick();
    expect_code(4'b0010, "R7 pending again on new rising edge");
    tx_empty = 0; tick();
    expect_code(4'b0001, "R7 cleared by input low");

    // Modem
    w_ier(4'b1000);
    msr_delta = 1; tick();
    @(negedge clk);
    chk(isr_code == 4'b0000 && irq, "R8 modem change code", isr_code, 0);

    // Priority ladder
    w_ier(4'b1111);
    tx_empty = 1; tick();
    expect_code(4'b0010, "R9 transmit above modem");
    push(8'h33, 3'b001);
    expect_code(4'b0110, "R9 line status above all");
    pop();
    w_fcr(8'h41);
    push(8'h44, 3'b000);
    idle(LIMIT + 2);
    expect_code(4'b1100, "R9 time-out above transmit");
    w_fcr(8'h01);
    expect_code(4'b0100, "R9 data above transmit");
    w_fcr(8'h03);
    expect_code(4'b0010, "R10 clear leaves transmit pending");
    msr_delta = 0; tx_empty = 0; tick();
    expect_code(4'b0001, "R9 none pending");

    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule